// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block sits beside a 16K-word memory shared by two ports, called left and right, and turns ordinary memory accesses into a doorbell between the two sides. Each side owns one reserved word near the top of the address space. When one side writes into the other side's reserved word, the owner's interrupt line goes active. The owner then reads its reserved word to take the message and drop its interrupt. The memory array and the meaning of the message stay outside this block, which decodes addresses and strobes only.

Each port gives a chip enable, a read/write select, an output enable, a 14-bit address and a busy indication. All of these are active low, and the block samples them on every rising clock edge. A port whose busy input is low has lost arbitration, so its accesses can neither raise the peer's interrupt nor clear its own. Each interrupt flag is a two-state machine with the states IDLE and RAISED. The transition RAISE goes from IDLE to RAISED. The transition TAKE goes from RAISED to IDLE. In every other case the flag stays where it is (HOLD). The interrupt line is low exactly while the flag is RAISED.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: The right port's reserved word is address 14'h3FFF and the left port's is 14'h3FFE. Accesses to any other address leave both interrupt lines unchanged.
- R2: A left write (lft_en_n=0, lft_wr_n=0) to 14'h3FFF with lft_busy_n=1 drives rgt_irq_n low after that clock edge. The line stays low until it is cleared.
- R3: A right write (rgt_en_n=0, rgt_wr_n=0) to 14'h3FFE with rgt_busy_n=1 drives lft_irq_n low after that clock edge.
- R4: A port reading its own reserved word (en_n=0, wr_n=1, oe_n=0) with its busy_n=1 drives its irq_n high after that clock edge.
- R5: Reading the other port's reserved word changes neither interrupt line.
- R6: A write made while the writer's busy_n is 0 does not raise the peer's interrupt.
- R7: A read of the port's own reserved word made while its busy_n is 0 does not clear its interrupt.
- R8: While rst is 1 at a clock edge, both interrupt lines go high, and they are high after reset ends.
- R9: When a set and a clear of the same flag fall on the same clock edge, the flag ends up RAISED.
- R10: A read with oe_n=1, any access with en_n=1, or a write by a port to its own reserved word does not clear that port's interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| lft_en_n | input | 1 | Left chip enable, active low |
| lft_wr_n | input | 1 | Left read/write select, 0 = write |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_addr | input | 14 | Left word address |
| lft_busy_n | input | 1 | Left busy, 0 = lost arbitration |
| rgt_en_n | input | 1 | Right chip enable, active low |
| rgt_wr_n | input | 1 | Right read/write select, 0 = write |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_addr | input | 14 | Right word address |
| rgt_busy_n | input | 1 | Right busy, 0 = lost arbitration |
| lft_irq_n | output | 1 | Left interrupt, active low |
| rgt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench aims at four corner cases. The first is a swapped mailbox decode, which would raise the writer's own line instead of the peer's. The second is a read of the peer's word that wrongly acknowledges, which would silently lose a pending message. The third is the busy gating on either path: a design without it would let a port that lost arbitration ring or acknowledge. The fourth is a set and a clear on the same edge, where a clear-wins design would drop a fresh message. The random stimulus is biased toward the two reserved addresses and mixes the strobes and busy levels, so all of these cases occur many times.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;

    typedef struct packed {
        logic set_peer;
        logic clr_own;
    } port_evt_t;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_pkg::*;
#(
    parameter int          AW       = 14,
    parameter logic [AW-1:0] OWN_BOX  = '1,
    parameter logic [AW-1:0] PEER_BOX = '1
) (
    input  logic          en_n,
    input  logic          wr_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic          busy_n,
    output port_evt_t     evt
);
    logic granted;
    logic is_write;
    logic is_read;

    always_comb begin
        granted      = ~en_n & busy_n;
        is_write     = ~wr_n;
        is_read      = wr_n & ~oe_n;
        evt.set_peer = granted & is_write & (addr == PEER_BOX);
        evt.clr_own  = granted & is_read  & (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raise,
    input  logic take,
    output logic irq_n
);
    flag_state_t state_q;
    flag_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (raise)         state_d = FLAG_RAISED;
            FLAG_RAISED: if (take && !raise) state_d = FLAG_IDLE;
            default:                        state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FLAG_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != FLAG_RAISED);
    end
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          lft_en_n,
    input  logic          lft_wr_n,
    input  logic          lft_oe_n,
    input  logic [AW-1:0] lft_addr,
    input  logic          lft_busy_n,
    input  logic          rgt_en_n,
    input  logic          rgt_wr_n,
    input  logic          rgt_oe_n,
    input  logic [AW-1:0] rgt_addr,
    input  logic          rgt_busy_n,
    output logic          lft_irq_n,
    output logic          rgt_irq_n
);
    localparam int          NPORT   = 2;
    localparam logic [AW-1:0] RGT_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] LFT_BOX = {{(AW-1){1'b1}}, 1'b0};

    logic [NPORT-1:0]         en_n;
    logic [NPORT-1:0]         wr_n;
    logic [NPORT-1:0]         oe_n;
    logic [NPORT-1:0]         busy_n;
    logic [NPORT-1:0][AW-1:0] addr;
    logic [NPORT-1:0]         irq_n;
    port_evt_t                evt [NPORT];

    always_comb begin
        en_n   = {rgt_en_n,   lft_en_n};
        wr_n   = {rgt_wr_n,   lft_wr_n};
        oe_n   = {rgt_oe_n,   lft_oe_n};
        busy_n = {rgt_busy_n, lft_busy_n};
        addr   = {rgt_addr,   lft_addr};
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_port
        localparam logic [AW-1:0] OWN  = (i == 0) ? LFT_BOX : RGT_BOX;
        localparam logic [AW-1:0] PEER = (i == 0) ? RGT_BOX : LFT_BOX;

        mbx_port_decode #(
            .AW       (AW),
            .OWN_BOX  (OWN),
            .PEER_BOX (PEER)
        ) u_dec (
            .en_n   (en_n[i]),
            .wr_n   (wr_n[i]),
            .oe_n   (oe_n[i]),
            .addr   (addr[i]),
            .busy_n (busy_n[i]),
            .evt    (evt[i])
        );

        mbx_flag_fsm u_flag (
            .clk   (clk),
            .rst   (rst),
            .raise (evt[NPORT-1-i].set_peer),
            .take  (evt[i].clr_own),
            .irq_n (irq_n[i])
        );
    end

    assign lft_irq_n = irq_n[0];
    assign rgt_irq_n = irq_n[1];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int AW = 14
) (
    input logic          clk,
    input logic          rst,
    input logic          lft_en_n,
    input logic          lft_wr_n,
    input logic          lft_oe_n,
    input logic [AW-1:0] lft_addr,
    input logic          lft_busy_n,
    input logic          rgt_en_n,
    input logic          rgt_wr_n,
    input logic          rgt_oe_n,
    input logic [AW-1:0] rgt_addr,
    input logic          rgt_busy_n,
    input logic          lft_irq_n,
    input logic          rgt_irq_n
);
    localparam logic [AW-1:0] R_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] L_BOX = R_BOX - 1'b1;

    wire l_ring = !lft_en_n && !lft_wr_n && lft_addr == R_BOX && lft_busy_n;
    wire r_ring = !rgt_en_n && !rgt_wr_n && rgt_addr == L_BOX && rgt_busy_n;
    wire l_ack  = !lft_en_n && lft_wr_n && !lft_oe_n && lft_addr == L_BOX && lft_busy_n;
    wire r_ack  = !rgt_en_n && rgt_wr_n && !rgt_oe_n && rgt_addr == R_BOX && rgt_busy_n;

    AST_RING_RIGHT: assert property (@(posedge clk) disable iff (rst) l_ring |=> !rgt_irq_n); // R2
    AST_RING_LEFT: assert property (@(posedge clk) disable iff (rst) r_ring |=> !lft_irq_n); // R3
    AST_ACK_LEFT: assert property (@(posedge clk) disable iff (rst) (l_ack && !r_ring) |=> lft_irq_n); // R4
    AST_ACK_RIGHT: assert property (@(posedge clk) disable iff (rst) (r_ack && !l_ring) |=> rgt_irq_n); // R4
    AST_BUSY_NO_RING: assert property (@(posedge clk) disable iff (rst) (rgt_irq_n && !lft_busy_n) |=> rgt_irq_n); // R6
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (rst) (!lft_irq_n && !lft_busy_n) |=> !lft_irq_n); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) (l_ring && r_ack) |=> !rgt_irq_n); // R9
    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (lft_irq_n && rgt_irq_n)); // R8
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!l_ring && !r_ring && !l_ack && !r_ack) |=> ($stable(lft_irq_n) && $stable(rgt_irq_n))); // R1
endmodule

bind mbx_irq_ctrl mbx_irq_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_mbx_irq_ctrl.sv
module sim_mbx_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        le_n = 1, lw_n = 1, lo_n = 1, lb_n = 1;
    logic        re_n = 1, rw_n = 1, ro_n = 1, rb_n = 1;
    logic [13:0] la = '0, ra = '0;
    logic        lirq_n, rirq_n;
    logic        exp_l = 1'b0, exp_r = 1'b0;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    mbx_irq_ctrl u0 (
        .clk(clk), .rst(rst),
        .lft_en_n(le_n), .lft_wr_n(lw_n), .lft_oe_n(lo_n), .lft_addr(la), .lft_busy_n(lb_n),
        .rgt_en_n(re_n), .rgt_wr_n(rw_n), .rgt_oe_n(ro_n), .rgt_addr(ra), .rgt_busy_n(rb_n),
        .lft_irq_n(lirq_n), .rgt_irq_n(rirq_n)
    );

    function automatic logic nxt_flag(logic cur, logic ring, logic ack);
        if (ring) return 1'b1;
        if (ack)  return 1'b0;
        return cur;
    endfunction

    task automatic idle();
        le_n = 1; lw_n = 1; lo_n = 1; lb_n = 1; la = '0;
        re_n = 1; rw_n = 1; ro_n = 1; rb_n = 1; ra = '0;
    endtask

    task automatic set_l(logic e, logic w, logic o, logic b, logic [13:0] a);
        le_n = e; lw_n = w; lo_n = o; lb_n = b; la = a;
    endtask

    task automatic set_r(logic e, logic w, logic o, logic b, logic [13:0] a);
        re_n = e; rw_n = w; ro_n = o; rb_n = b; ra = a;
    endtask

    // Advance one edge with the current inputs, then compare both lines.
    task automatic step(string tag);
        logic l_ring, r_ring, l_ack, r_ack;
        l_ring = !le_n && !lw_n && la == 14'h3FFF && lb_n;
        r_ring = !re_n && !rw_n && ra == 14'h3FFE && rb_n;
        l_ack  = !le_n && lw_n && !lo_n && la == 14'h3FFE && lb_n;
        r_ack  = !re_n && rw_n && !ro_n && ra == 14'h3FFF && rb_n;
        if (rst) begin
            exp_l = 1'b0; exp_r = 1'b0;
        end else begin
            exp_l = nxt_flag(exp_l, r_ring, l_ack);
            exp_r = nxt_flag(exp_r, l_ring, r_ack);
        end
        @(negedge clk);
        checks++;
        if (lirq_n !== !exp_l || rirq_n !== !exp_r) begin
            errors++;
            $display("FAIL %s: lft_irq_n=%b rgt_irq_n=%b expected %b %b",
                     tag, lirq_n, rirq_n, !exp_l, !exp_r);
        end
    endtask

    function automatic logic [13:0] pick_addr();
        int unsigned k = $urandom_range(0, 7);
        if (k < 3) return 14'h3FFE;
        if (k < 6) return 14'h3FFF;
        return 14'($urandom);
    endfunction

    initial begin
        #4000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        @(negedge clk);
        step("R8 reset");
        rst = 1'b0;
        step("R8 after reset");

        set_l(0, 0, 1, 1, 14'h3FFF); step("R2 left rings right");
        idle(); step("R2 held");
        set_l(0, 1, 0, 1, 14'h3FFF); step("R5 peer read no effect");
        set_r(0, 1, 0, 0, 14'h3FFF); step("R7 busy blocks ack");
        set_r(0, 1, 1, 1, 14'h3FFF); step("R10 oe high no ack");
        set_r(1, 1, 0, 1, 14'h3FFF); step("R10 en high no ack");
        set_r(0, 0, 1, 1, 14'h3FFF); step("R10 own-box write no ack");
        set_r(0, 1, 0, 1, 14'h3FFF); step("R4 right ack");
        idle();
        set_r(0, 0, 1, 0, 14'h3FFE); step("R6 busy blocks ring");
        set_r(0, 0, 1, 1, 14'h3FFD); step("R1 other address no ring");
        set_r(0, 0, 1, 1, 14'h3FFE); step("R3 right rings left");
        idle();
        set_l(0, 1, 0, 1, 14'h3FFE); set_r(0, 0, 1, 1, 14'h3FFE);
        step("R9 set wins");
        idle();
        set_l(0, 1, 0, 1, 14'h3FFE); step("R4 left ack");
        idle();
        set_l(0, 0, 1, 1, 14'h3FFF); step("R2 ring before reset");
        idle(); rst = 1'b1; step("R8 mid-run reset");
        rst = 1'b0;

        for (int n = 0; n < 600; n++) begin
            set_l(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                  1'($urandom_range(0, 3) != 0), pick_addr());
            set_r(1'($urandom_range(0, 3) == 0), 1'($urandom), 1'($urandom),
                  1'($urandom_range(0, 3) != 0), pick_addr());
            step("R1 random");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule